// File: doc/BRIEF.md
# Framed Byte Mailbox Host Interface

This block is the device side of a byte-wide, two-port host mailbox that carries command and response packets. A simple host bus with a one-bit address, read and write strobes and 8-bit data reaches a data port at address 0. Address 1 is a shared port: a read returns a status byte and a write is taken as a mode command. Command bytes the host writes to the data port go out on a ready/valid stream to an internal processing engine. Response bytes come back from that engine on a second ready/valid stream.

The block owns all status flags and decodes the host's mode commands: open a packet, close a packet, and abort. It frames each response for the host. A framing flag together with a leading marker byte announces the response. The payload follows one byte at a time. A second framing flag with a closing marker byte ends it. The host learns every transfer step by polling the status byte. The abort command returns the mailbox to a bare ready state at any point.

Top module: `mbox_host_if`

## Requirements
- R1: After reset the status byte reads 0x10: only ready-for-command (bit 4) is set. Output-full (bit 0), input-full (bit 1), frame flag (bit 2), busy (bit 3), ready-for-data (bit 5) and overrun (bit 6) are all clear. No command byte is offered and no response byte is taken.
- R2: Address 0 is the data port. A read at address 1 returns status, and a write at address 1 is a command. Read data is valid in the same cycle as the read strobe.
- R3: When ready-for-command is set, command code 0x01 opens a packet. The status then reads 0x20: ready-for-data (bit 5) is set and ready-for-command (bit 4) is cleared. Bits 4 and 5 are never set together.
- R4: A data-port write while ready-for-data is set stores the byte, sets input-full (bit 1) and offers the byte on the command stream. Input-full clears on the edge where the engine accepts the byte. Bytes reach the engine in the order written.
- R5: A data-port write while input-full is set is dropped and sets the sticky overrun bit (bit 6). A data-port write while ready-for-data is clear is ignored and leaves the status unchanged.
- R6: Command 0x03 while ready-for-data is set closes the packet. It clears bit 5, sets busy (bit 3), and raises the packet-end output for exactly one cycle.
- R7: While busy, once the engine offers the first response byte, the status reads 0x0D (output-full, frame flag and busy set), and the data port returns the leading marker 0x01.
- R8: Each payload byte is presented with output-full set and the frame flag clear (status 0x09), in the order the engine delivers them. A data-port read clears output-full on the next edge. The next byte is loaded one cycle later.
- R9: After the last payload byte is read, the status reads 0x0D and the data port returns the closing marker 0x03. Reading that marker leaves the status at 0x10.
- R10: Command 0x22 in any state makes the status read exactly 0x10 from the next cycle on. This also clears the overrun bit.
- R11: Every command code other than 0x01, 0x03 and 0x22, and 0x01 or 0x03 written in a state where it does not apply, leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | 1 | Port select: 0 data, 1 status/command |
| hst_rd | input | 1 | Host read strobe, one cycle per access |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data (data byte or status) |
| cmd_tdata | output | 8 | Command byte to the engine |
| cmd_tvalid | output | 1 | Command byte valid |
| cmd_tready | input | 1 | Engine accepts the command byte |
| pkt_end | output | 1 | One-cycle pulse when the host closes a packet |
| rsp_tdata | input | 8 | Response byte from the engine |
| rsp_tvalid | input | 1 | Response byte valid |
| rsp_tlast | input | 1 | Marks the last response byte |
| rsp_tready | output | 1 | Mailbox accepts the response byte |

## Verification
The bench uses the default 8-bit byte width. At this width the full command space is small enough to sweep: all 256 command codes are written from the idle state, and each is followed by an abort. This shows that only the open code and the abort change the status. Packets of one to eight bytes are then pushed in and answered with responses of matching length. The byte values are computed from the packet length and the byte index. This covers the shortest response and back-to-back payload pops. A stalled engine brings the overrun path and its clearing by abort within reach.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] OP_OPEN  = 8'h01;
    localparam logic [DATA_W-1:0] OP_CLOSE = 8'h03;
    localparam logic [DATA_W-1:0] OP_ABORT = 8'h22;

    localparam logic [DATA_W-1:0] MARK_HEAD = 8'h01;
    localparam logic [DATA_W-1:0] MARK_TAIL = 8'h03;

    // Field order is decoded by the host: LSB is output-full.
    typedef struct packed {
        logic spare;
        logic ovr;
        logic rdy_data;
        logic rdy_cmd;
        logic busy;
        logic frame;
        logic in_full;
        logic out_full;
    } mbox_stat_t;

    typedef enum logic [1:0] {
        OUT_IDLE,
        OUT_BODY,
        OUT_TAIL,
        OUT_END
    } out_state_t;

    function automatic mbox_stat_t pack_stat(
        input logic out_full, input logic in_full, input logic frame,
        input logic busy, input logic rdy_cmd, input logic rdy_data,
        input logic ovr);
        mbox_stat_t s;
        s.spare    = 1'b0;
        s.ovr      = ovr;
        s.rdy_data = rdy_data;
        s.rdy_cmd  = rdy_cmd;
        s.busy     = busy;
        s.frame    = frame;
        s.in_full  = in_full;
        s.out_full = out_full;
        return s;
    endfunction
endpackage

// File: rtl/mbox_inbound.sv
module mbox_inbound #(
    parameter int DW = mbox_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          open,
    input  logic          close,
    input  logic          wr_data,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] tdata,
    output logic          tvalid,
    input  logic          tready,
    output logic          in_full,
    output logic          rdy_data,
    output logic          ovr,
    output logic          end_pulse
);
    logic [DW-1:0] hold_q;
    logic          full_q;
    logic          rdy_q;
    logic          ovr_q;
    logic          end_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            hold_q <= '0;
            full_q <= 1'b0;
            rdy_q  <= 1'b0;
            ovr_q  <= 1'b0;
            end_q  <= 1'b0;
        end else begin
            end_q <= close;
            if (open)
                rdy_q <= 1'b1;
            else if (close)
                rdy_q <= 1'b0;

            if (wr_data && rdy_q && full_q) begin
                ovr_q <= 1'b1;
            end else if (wr_data && rdy_q) begin
                hold_q <= wdata;
                full_q <= 1'b1;
            end

            if (full_q && tready)
                full_q <= 1'b0;
        end
    end

    assign tdata     = hold_q;
    assign tvalid    = full_q;
    assign in_full   = full_q;
    assign rdy_data  = rdy_q;
    assign ovr       = ovr_q;
    assign end_pulse = end_q;
endmodule

// File: rtl/mbox_outbound.sv
module mbox_outbound #(
    parameter int DW = mbox_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          armed,
    input  logic          rd_data,
    input  logic [DW-1:0] rsp_tdata,
    input  logic          rsp_tvalid,
    input  logic          rsp_tlast,
    output logic          rsp_tready,
    output logic [DW-1:0] dout,
    output logic          out_full,
    output logic          frame,
    output logic          done
);
    import mbox_pkg::*;

    out_state_t    st_q;
    logic [DW-1:0] dout_q;
    logic          full_q;
    logic          frame_q;
    logic          take;

    assign take       = rd_data && full_q;
    assign rsp_tready = (st_q == OUT_BODY) && !full_q;
    assign done       = (st_q == OUT_END) && take;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st_q    <= OUT_IDLE;
            dout_q  <= '0;
            full_q  <= 1'b0;
            frame_q <= 1'b0;
        end else if (take) begin
            full_q  <= 1'b0;
            frame_q <= 1'b0;
            if (st_q == OUT_END)
                st_q <= OUT_IDLE;
        end else if (!full_q) begin
            case (st_q)
                OUT_IDLE: if (armed && rsp_tvalid) begin
                    dout_q  <= MARK_HEAD;
                    full_q  <= 1'b1;
                    frame_q <= 1'b1;
                    st_q    <= OUT_BODY;
                end
                OUT_BODY: if (rsp_tvalid) begin
                    dout_q <= rsp_tdata;
                    full_q <= 1'b1;
                    if (rsp_tlast)
                        st_q <= OUT_TAIL;
                end
                OUT_TAIL: begin
                    dout_q  <= MARK_TAIL;
                    full_q  <= 1'b1;
                    frame_q <= 1'b1;
                    st_q    <= OUT_END;
                end
                default: ;
            endcase
        end
    end

    assign dout     = dout_q;
    assign out_full = full_q;
    assign frame    = frame_q;
endmodule

// File: rtl/mbox_host_if.sv
module mbox_host_if #(
    parameter int DW = mbox_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hst_addr,
    input  logic          hst_rd,
    input  logic          hst_wr,
    input  logic [DW-1:0] hst_wdata,
    output logic [DW-1:0] hst_rdata,
    output logic [DW-1:0] cmd_tdata,
    output logic          cmd_tvalid,
    input  logic          cmd_tready,
    output logic          pkt_end,
    input  logic [DW-1:0] rsp_tdata,
    input  logic          rsp_tvalid,
    input  logic          rsp_tlast,
    output logic          rsp_tready
);
    import mbox_pkg::*;

    logic       wr_cmd, wr_dat, rd_dat;
    logic       is_open, is_close, is_abort;
    logic       rdy_cmd_q, busy_q;
    logic       in_full, rdy_data, ovr;
    logic       out_full, frame, done;
    logic [DW-1:0] dout;
    mbox_stat_t stat;

    assign wr_cmd   = hst_wr && hst_addr;
    assign wr_dat   = hst_wr && !hst_addr;
    assign rd_dat   = hst_rd && !hst_addr;
    assign is_abort = wr_cmd && (hst_wdata == OP_ABORT);
    assign is_open  = wr_cmd && (hst_wdata == OP_OPEN) && rdy_cmd_q;
    assign is_close = wr_cmd && (hst_wdata == OP_CLOSE) && rdy_data;

    // Session flags: ready-for-command and busy (response pending).
    always_ff @(posedge clk) begin
        if (rst || is_abort) begin
            rdy_cmd_q <= 1'b1;
            busy_q    <= 1'b0;
        end else begin
            if (is_open)
                rdy_cmd_q <= 1'b0;
            else if (done)
                rdy_cmd_q <= 1'b1;
            if (is_close)
                busy_q <= 1'b1;
            else if (done)
                busy_q <= 1'b0;
        end
    end

    mbox_inbound #(.DW(DW)) u_in (
        .clk       (clk),
        .rst       (rst),
        .abort     (is_abort),
        .open      (is_open),
        .close     (is_close),
        .wr_data   (wr_dat),
        .wdata     (hst_wdata),
        .tdata     (cmd_tdata),
        .tvalid    (cmd_tvalid),
        .tready    (cmd_tready),
        .in_full   (in_full),
        .rdy_data  (rdy_data),
        .ovr       (ovr),
        .end_pulse (pkt_end)
    );

    mbox_outbound #(.DW(DW)) u_out (
        .clk        (clk),
        .rst        (rst),
        .abort      (is_abort),
        .armed      (busy_q),
        .rd_data    (rd_dat),
        .rsp_tdata  (rsp_tdata),
        .rsp_tvalid (rsp_tvalid),
        .rsp_tlast  (rsp_tlast),
        .rsp_tready (rsp_tready),
        .dout       (dout),
        .out_full   (out_full),
        .frame      (frame),
        .done       (done)
    );

    assign stat = pack_stat(out_full, in_full, frame, busy_q,
                            rdy_cmd_q, rdy_data, ovr);

    assign hst_rdata = hst_addr ? DW'(stat) : dout;
endmodule

// File: rtl/mbox_host_if_chk.sv
module mbox_host_if_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] stat,
    input logic       is_abort,
    input logic       rd_dat,
    input logic       cmd_tvalid,
    input logic       cmd_tready,
    input logic       pkt_end
);
    a_r10_abort_bare: assert property (@(posedge clk) disable iff (rst)
        is_abort |=> (stat == 8'h10));

    a_r4_in_full_clears: assert property (@(posedge clk) disable iff (rst)
        (cmd_tvalid && cmd_tready) |=> !stat[1]);

    a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
        (stat[6] && !is_abort) |=> stat[6]);

    a_r8_read_clears_full: assert property (@(posedge clk) disable iff (rst)
        (rd_dat && stat[0]) |=> !stat[0]);

    a_r7_frame_needs_full: assert property (@(posedge clk) disable iff (rst)
        stat[2] |-> stat[0]);

    a_r3_ready_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(stat[4] && stat[5]));

    a_r6_end_single: assert property (@(posedge clk) disable iff (rst)
        pkt_end |=> !pkt_end);
endmodule

bind mbox_host_if mbox_host_if_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .stat       (stat),
    .is_abort   (is_abort),
    .rd_dat     (rd_dat),
    .cmd_tvalid (cmd_tvalid),
    .cmd_tready (cmd_tready),
    .pkt_end    (pkt_end)
);

// File: tb/tb_mbox_host_if.sv
`timescale 1ns/1ps
module tb_mbox_host_if;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hst_addr = 1'b0;
    logic       hst_rd = 1'b0;
    logic       hst_wr = 1'b0;
    logic [7:0] hst_wdata = '0;
    logic [7:0] hst_rdata;
    logic [7:0] cmd_tdata;
    logic       cmd_tvalid;
    logic       cmd_tready = 1'b1;
    logic       pkt_end;
    logic [7:0] rsp_tdata;
    logic       rsp_tvalid;
    logic       rsp_tlast;
    logic       rsp_tready;

    always #2.5 clk = ~clk;

    mbox_host_if dut (
        .clk(clk), .rst(rst), .hst_addr(hst_addr), .hst_rd(hst_rd),
        .hst_wr(hst_wr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .cmd_tdata(cmd_tdata), .cmd_tvalid(cmd_tvalid), .cmd_tready(cmd_tready),
        .pkt_end(pkt_end), .rsp_tdata(rsp_tdata), .rsp_tvalid(rsp_tvalid),
        .rsp_tlast(rsp_tlast), .rsp_tready(rsp_tready)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Engine model: capture buffer and response source.
    logic [7:0] cap [0:15];
    int         n_cap = 0;
    int         n_end = 0;
    logic [7:0] rsp_mem [0:15];
    int         rsp_len = 0;
    int         rsp_idx = 0;
    bit         rsp_go = 0;

    assign rsp_tvalid = rsp_go && (rsp_idx < rsp_len);
    assign rsp_tdata  = rsp_mem[rsp_idx[3:0]];
    assign rsp_tlast  = (rsp_idx == rsp_len - 1);

    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst && cmd_tvalid && cmd_tready) begin
                cap[n_cap[3:0]] = cmd_tdata;
                n_cap++;
            end
            if (!rst && pkt_end) n_end++;
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (!rst && rsp_tvalid && rsp_tready) begin
                @(posedge clk);
                #1 rsp_idx++;
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic hwr(input logic a, input logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        @(posedge clk);
        #1 hst_wr = 1'b0;
    endtask

    task automatic hrd(input logic a, output logic [7:0] d);
        @(negedge clk);
        hst_addr = a; hst_rd = 1'b1;
        #1 d = hst_rdata;
        @(posedge clk);
        #1 hst_rd = 1'b0;
    endtask

    task automatic poll(input logic [7:0] mask, output logic [7:0] s);
        s = '0;
        for (int i = 0; i < 50; i++) begin
            hrd(1'b1, s);
            if ((s & mask) == mask) break;
        end
    endtask

    task automatic poll_in_empty();
        logic [7:0] s;
        for (int i = 0; i < 50; i++) begin
            hrd(1'b1, s);
            if (!s[1]) break;
        end
    endtask

    initial begin
        logic [7:0] s, d;
        int base_end;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        hrd(1'b1, s);
        chk("R1 reset status", s, 8'h10);
        chk("R1 no command byte", {7'd0, cmd_tvalid}, 8'h00);
        chk("R1 no response taken", {7'd0, rsp_tready}, 8'h00);

        // R3/R10/R11/R2: sweep every command code from idle
        for (int c = 0; c < 256; c++) begin
            hwr(1'b1, 8'(c));
            hrd(1'b1, s);
            if (c == 1) chk("R3 open status", s, 8'h20);
            else        chk("R11 code ignored", s, 8'h10);
            hwr(1'b1, 8'h22);
            hrd(1'b1, s);
            chk("R10 abort status", s, 8'h10);
        end

        // R5: data write while not ready-for-data is ignored
        hwr(1'b0, 8'hA5);
        hrd(1'b1, s);
        chk("R5 stray data status", s, 8'h10);
        chk("R5 stray data no valid", {7'd0, cmd_tvalid}, 8'h00);

        // R4..R9: packets and responses of lengths 1..8
        for (int len = 1; len <= 8; len++) begin
            n_cap = 0;
            base_end = n_end;
            hwr(1'b1, 8'h01);
            for (int k = 0; k < len; k++) begin
                hwr(1'b0, 8'(k * 37 + len * 11));
                if (k == 0) begin
                    hrd(1'b1, s);
                    chk("R4 input-full after write", s, 8'h22);
                end
                poll_in_empty();
            end
            hwr(1'b1, 8'h03);
            hrd(1'b1, s);
            chk("R6 close status", s, 8'h08);
            repeat (2) @(negedge clk);
            chk("R6 one end pulse", 8'(n_end - base_end), 8'd1);
            chk("R4 byte count", 8'(n_cap), 8'(len));
            for (int k = 0; k < len; k++)
                chk("R4 byte order", cap[k], 8'(k * 37 + len * 11));

            for (int k = 0; k < len; k++) rsp_mem[k] = 8'(k * 53 + len * 7 + 1);
            rsp_idx = 0;
            rsp_len = len;
            rsp_go  = 1;

            poll(8'h04, s);
            chk("R7 head status", s, 8'h0D);
            hrd(1'b0, d);
            chk("R7 head marker", d, 8'h01);
            for (int k = 0; k < len; k++) begin
                hrd(1'b1, s);
                chk("R8 gap after read", s, 8'h08);
                hrd(1'b1, s);
                chk("R8 payload status", s, 8'h09);
                hrd(1'b0, d);
                chk("R8 payload byte", d, 8'(k * 53 + len * 7 + 1));
            end
            hrd(1'b1, s);
            hrd(1'b1, s);
            chk("R9 tail status", s, 8'h0D);
            hrd(1'b0, d);
            chk("R9 tail marker", d, 8'h03);
            hrd(1'b1, s);
            chk("R9 back to ready", s, 8'h10);
            rsp_go = 0;
        end

        // R5/R10: overrun with stalled engine
        n_cap = 0;
        cmd_tready = 1'b0;
        hwr(1'b1, 8'h01);
        hwr(1'b0, 8'h5A);
        hwr(1'b0, 8'hC3);
        hrd(1'b1, s);
        chk("R5 overrun status", s, 8'h62);
        chk("R5 first byte kept", cmd_tdata, 8'h5A);
        @(negedge clk);
        cmd_tready = 1'b1;
        repeat (3) @(negedge clk);
        hrd(1'b1, s);
        chk("R5 overrun sticky", s, 8'h60);
        chk("R5 dropped byte absent", 8'(n_cap), 8'd1);
        hwr(1'b1, 8'h07);
        hrd(1'b1, s);
        chk("R11 bad code in session", s, 8'h60);
        hwr(1'b1, 8'h22);
        hrd(1'b1, s);
        chk("R10 abort clears overrun", s, 8'h10);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule